// File: doc/BRIEF.md
# Compare Flags and Branch Unit

This block keeps a hidden 16-bit flags value and resolves relative jumps for a 16-bit processor with fixed 4-byte instructions. A compare instruction, in either the register-register form or the register-immediate form, stores the wrapped difference of its two operands. No other instruction touches that value, and no register operand can name it. The value is read as a signed two's-complement number.

Each cycle the unit takes one decoded opcode, a valid strobe, two already-selected operands, a 16-bit offset and the current instruction pointer. A jump opcode tests the stored value. If the jump is taken, the next instruction pointer is the address of the following instruction plus the offset. Otherwise execution falls through to the following instruction. The result is combinational in the same cycle. A compare takes effect at the next clock edge, so a jump in the following cycle sees the new value.

Alongside the stored difference, a state machine keeps its sign class. The states are `SGN_ZERO` (the reset state), `SGN_NEG` and `SGN_POS`. There is one kind of transition: from any state, a valid compare moves the machine to the class of the new difference. In all other cycles the machine stays in its current state.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset the stored difference is zero, so the equal-jump (0x21) is taken and the less-jump (0x23) is not.
- R2: A valid compare with opcode 0x53 stores `opnd_a - opnd_b` modulo 2^16 at the next clock edge.
- R3: A valid compare with opcode 0x54 (immediate form, the immediate arriving on `opnd_b`) also stores `opnd_a - opnd_b` modulo 2^16.
- R4: Only a valid compare changes the stored difference. Arithmetic opcodes (such as 0x10) and a compare with `op_valid` low leave it unchanged.
- R5: Jump conditions are tested on the stored value read as signed. 0x21 is taken when it is zero, 0x22 when it is non-zero, 0x23 when it is negative, 0x24 when it is negative or zero, 0x25 when it is positive, and 0x26 when it is zero or positive.
- R6: For a taken jump, `next_ip = cur_ip + 4 + jmp_offset` modulo 2^16.
- R7: When no jump is taken, including for every non-jump opcode, `jump_taken` is 0 and `next_ip = cur_ip + 4` modulo 2^16.
- R8: Opcode 0x20 with `op_valid` high is always taken.
- R9: The subtraction wraps. 0x8000 − 0x0001 gives 0x7FFF, which is positive. 0x7FFF − 0xFFFF gives 0x8000, which is negative.
- R10: `jump_taken` is 0 whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Decoded opcode |
| opnd_a | input | 16 | First compare operand |
| opnd_b | input | 16 | Second compare operand (register value or immediate) |
| jmp_offset | input | 16 | Signed relative jump offset |
| cur_ip | input | 16 | Address of the current instruction |
| jump_taken | output | 1 | Jump is taken this cycle |
| next_ip | output | 16 | Address of the next instruction |

## Verification
The bench builds the unit with its default parameters: 16-bit data, 16-bit addresses and a 4-byte instruction step. With these values, 0x7FFF/0x8000 and 0xFFFF are the operand patterns that push the subtraction across the signed limits. An instruction pointer near 0xFFFF makes both the fall-through step and a negative offset wrap. Every one of the six conditions is driven from each of the three sign classes.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_JMP     = 8'h20;
    localparam logic [OP_W-1:0] OP_JEQ     = 8'h21;
    localparam logic [OP_W-1:0] OP_JNE     = 8'h22;
    localparam logic [OP_W-1:0] OP_JLT     = 8'h23;
    localparam logic [OP_W-1:0] OP_JLE     = 8'h24;
    localparam logic [OP_W-1:0] OP_JGT     = 8'h25;
    localparam logic [OP_W-1:0] OP_JGE     = 8'h26;
    localparam logic [OP_W-1:0] OP_CMP_RR  = 8'h53;
    localparam logic [OP_W-1:0] OP_CMP_RI  = 8'h54;

    typedef enum logic [1:0] {
        SGN_ZERO = 2'd0,
        SGN_NEG  = 2'd1,
        SGN_POS  = 2'd2
    } sgn_state_e;

    function automatic logic is_compare(input logic [OP_W-1:0] op);
        return (op == OP_CMP_RR) || (op == OP_CMP_RI);
    endfunction

    function automatic logic is_jump(input logic [OP_W-1:0] op);
        return (op >= OP_JMP) && (op <= OP_JGE);
    endfunction

endpackage

// File: rtl/cbu_flags.sv
module cbu_flags
    import cbu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] diff_q,
    output sgn_state_e        sgn_q
);

    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W-1:0] diff_d;
    sgn_state_e        sgn_d;
    sgn_state_e        new_class;

    always_comb begin
        diff_d = lhs - rhs;
        if (diff_d == ZERO) begin
            new_class = SGN_ZERO;
        end else if (diff_d[DATA_W-1]) begin
            new_class = SGN_NEG;
        end else begin
            new_class = SGN_POS;
        end
    end

    // Next-state process: a compare moves to the class of the new difference.
    always_comb begin
        sgn_d = sgn_q;
        unique case (sgn_q)
            SGN_ZERO: if (wr_en) sgn_d = new_class;
            SGN_NEG:  if (wr_en) sgn_d = new_class;
            SGN_POS:  if (wr_en) sgn_d = new_class;
            default:  sgn_d = SGN_ZERO;
        endcase
    end

    // State register and stored difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q  <= SGN_ZERO;
            diff_q <= ZERO;
        end else begin
            sgn_q <= sgn_d;
            if (wr_en) begin
                diff_q <= diff_d;
            end
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(diff_q) && $stable(sgn_q)); // R4

    AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> diff_q == $past(lhs - rhs)); // R2

    AST_NEG_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        sgn_q == SGN_NEG |-> diff_q[DATA_W-1]); // R5

    AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (sgn_q == SGN_ZERO) == (diff_q == ZERO)); // R1

endmodule

// File: rtl/cbu_cond.sv
module cbu_cond
    import cbu_pkg::*;
(
    input  logic            valid,
    input  logic [OP_W-1:0] op,
    input  sgn_state_e      sgn,
    output logic            take
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (sgn == SGN_ZERO);
    assign is_neg  = (sgn == SGN_NEG);

    always_comb begin
        take = 1'b0;
        if (valid) begin
            unique case (op)
                OP_JMP:  take = 1'b1;
                OP_JEQ:  take = is_zero;
                OP_JNE:  take = !is_zero;
                OP_JLT:  take = is_neg;
                OP_JLE:  take = is_neg || is_zero;
                OP_JGT:  take = !is_neg && !is_zero;
                OP_JGE:  take = !is_neg;
                default: take = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cbu_target.sv
module cbu_target #(
    parameter int ADDR_W     = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] ip,
    input  logic [ADDR_W-1:0] offset,
    input  logic              take,
    output logic [ADDR_W-1:0] nxt
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] seq_ip;

    always_comb begin
        seq_ip = ip + STEP;
        nxt    = take ? (seq_ip + offset) : seq_ip;
    end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] jmp_offset,
    input  logic [ADDR_W-1:0] cur_ip,
    output logic              jump_taken,
    output logic [ADDR_W-1:0] next_ip
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic              cmp_wr;
    logic [DATA_W-1:0] diff_q;
    sgn_state_e        sgn_q;

    assign cmp_wr = op_valid && is_compare(opcode);

    cbu_flags #(.DATA_W(DATA_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmp_wr),
        .lhs    (opnd_a),
        .rhs    (opnd_b),
        .diff_q (diff_q),
        .sgn_q  (sgn_q)
    );

    cbu_cond u_cond (
        .valid (op_valid),
        .op    (opcode),
        .sgn   (sgn_q),
        .take  (jump_taken)
    );

    cbu_target #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_target (
        .ip     (cur_ip),
        .offset (jmp_offset),
        .take   (jump_taken),
        .nxt    (next_ip)
    );

    AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && opcode == OP_JMP |-> jump_taken); // R8

    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !jump_taken); // R10

    AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !jump_taken |-> next_ip == cur_ip + STEP); // R7

    AST_TAKE_IS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        jump_taken |-> is_jump(opcode)); // R7

endmodule

// File: tb/cmp_branch_unit_test.sv
`timescale 1ns/1ps
module cmp_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h90;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] jmp_offset = '0;
    logic [15:0] cur_ip = '0;
    logic        jump_taken;
    logic [15:0] next_ip;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdiff = '0;

    always #5 clk = ~clk;

    cmp_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .jmp_offset(jmp_offset),
        .cur_ip(cur_ip), .jump_taken(jump_taken), .next_ip(next_ip)
    );

    function automatic logic exp_take(input logic v, input logic [7:0] op, input logic [15:0] d);
        logic signed [15:0] s;
        s = $signed(d);
        if (!v) return 1'b0;
        case (op)
            8'h20: return 1'b1;
            8'h21: return s == 0;
            8'h22: return s != 0;
            8'h23: return s < 0;
            8'h24: return s <= 0;
            8'h25: return s > 0;
            8'h26: return s >= 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [7:0] op,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] off, input logic [15:0] ip);
        logic t;
        @(negedge clk);
        op_valid = v; opcode = op; opnd_a = a; opnd_b = b;
        jmp_offset = off; cur_ip = ip;
        #1;
        t = exp_take(v, op, mdiff);
        chk({tag, " taken"}, {31'd0, jump_taken}, {31'd0, t});
        chk({tag, " next_ip"}, {16'd0, next_ip}, {16'd0, t ? ip + 16'd4 + off : ip + 16'd4});
        if (v && (op == 8'h53 || op == 8'h54)) mdiff = a - b;
    endtask

    task automatic all_conds(input string tag);
        for (int c = 8'h21; c <= 8'h26; c++) begin
            step(tag, 1'b1, 8'(c), 16'h0, 16'h0, 16'h0040, 16'h0100);
        end
    endtask

    task automatic t_reset;
        step("R1 eq after reset", 1'b1, 8'h21, 0, 0, 16'h0010, 16'h0000);
        step("R1 lt after reset", 1'b1, 8'h23, 0, 0, 16'h0010, 16'h0000);
    endtask

    task automatic t_cmp_reg;
        step("R2 cmp rr equal", 1'b1, 8'h53, 16'd5, 16'd5, 0, 16'h0200);
        all_conds("R5 zero class");
        step("R2 cmp rr pos", 1'b1, 8'h53, 16'd900, 16'd12, 0, 16'h0200);
        all_conds("R5 pos class");
    endtask

    task automatic t_cmp_imm;
        step("R3 cmp imm neg", 1'b1, 8'h54, 16'd3, 16'd10, 0, 16'h0300);
        all_conds("R5 neg class");
    endtask

    task automatic t_wrap;
        step("R9 cmp 8000-1", 1'b1, 8'h53, 16'h8000, 16'h0001, 0, 0);
        step("R9 jg after wrap", 1'b1, 8'h25, 0, 0, 16'h0008, 16'h0400);
        step("R9 cmp 7fff-ffff", 1'b1, 8'h54, 16'h7FFF, 16'hFFFF, 0, 0);
        step("R9 jl after wrap", 1'b1, 8'h23, 0, 0, 16'h0008, 16'h0400);
    endtask

    task automatic t_no_write;
        step("R4 set zero", 1'b1, 8'h53, 16'd7, 16'd7, 0, 0);
        step("R4 add opcode", 1'b1, 8'h10, 16'd9, 16'd1, 0, 0);
        step("R4 eq after add", 1'b1, 8'h21, 0, 0, 16'h0020, 16'h0500);
        step("R4 cmp not valid", 1'b0, 8'h53, 16'd1, 16'd9, 0, 0);
        step("R4 eq after idle cmp", 1'b1, 8'h21, 0, 0, 16'h0020, 16'h0500);
    endtask

    task automatic t_targets;
        step("R8 R6 jmp back wrap", 1'b1, 8'h20, 0, 0, 16'hFFE8, 16'h0010);
        step("R6 jmp forward", 1'b1, 8'h20, 0, 0, 16'h0100, 16'h1000);
        step("R7 fallthrough wrap", 1'b1, 8'h22, 0, 0, 16'h0100, 16'hFFFE);
        step("R7 nop opcode", 1'b1, 8'h90, 0, 0, 16'h0100, 16'h2000);
        step("R10 jmp not valid", 1'b0, 8'h20, 0, 0, 16'h0100, 16'h2000);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmp_reg();
        t_cmp_imm();
        t_wrap();
        t_no_write();
        t_targets();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule